// File: doc/BRIEF.md
# Clock Generator Control Register

This block holds the 8-bit control word of a clock and reset generator and the small amount of logic that hangs directly off it. Software uses a single-cycle bus port to turn the oscillator on, pick where the bus clock comes from, pick where the frequency-locked loop gets its reference, set the oscillator noise-filter bandwidth, and choose a reference divide ratio. Several fields are guarded. The two clock-source selects only take a 1 while the oscillator reports that it has started. They also drop back to 0 whenever the oscillator is off or stop mode is requested. The filter bit can only be changed while the oscillator is disabled.

The stored divide code drives a counter that turns oscillator cycles into a one-cycle reference tick. Oscillator cycles arrive as `osc_pulse`, a one-per-cycle strobe already brought into the block clock domain. The bus-clock select drives registered select lines for the bus clock multiplexer and a DCO shut-off line. Every write, whatever its data, produces a one-cycle pulse that clears the lock-status bit held elsewhere.

Top module: `clkctl_top`

## Requirements
- R1: Register layout is: bit 7 oscillator enable; bits 6:4 divide code; bit 3 bus clock from oscillator; bit 2 loop reference from oscillator; bit 1 low-bandwidth filter. Bit 0 always reads 0, whatever value is written to it.
- R2: After reset, every register bit is 0, `ref_tick` and `lock_clr` are 0, and the bus clock selects the DCO.
- R3: Divide codes 0 to 6 give ratios 128, 160, 192, 256, 320, 384 and 512. With `osc_pulse` held high, consecutive `ref_tick` pulses are exactly that many cycles apart, and each tick lasts one cycle.
- R4: A write of 1 to bit 3 takes effect only if `osc_ready` is 1 in the cycle of the write. Otherwise bit 3 keeps its value. A write of 0 always clears it.
- R5: Bit 2 follows the same write rule as bit 3, using `osc_ready`.
- R6: Bits 3 and 2 are 0 in any cycle after an edge at which the oscillator enable (the new value) is 0 or `stop_req` is 1.
- R7: A write changes bit 1 only if the oscillator enable bit was 0 before that write. Otherwise bit 1 keeps its value.
- R8: Every write makes `lock_clr` high for exactly the one cycle that follows the write.
- R9: One cycle after bit 3 changes, `bus_sel_osc` and `dco_off` equal the new value and `bus_sel_dco` equals its inverse.
- R10: A write of divide code 7 leaves the stored divide code unchanged. The other fields of that write still apply.
- R11: After the divide code changes, the counter restarts. The first tick appears N+1 cycles after the register update. While the oscillator enable bit is 0, no tick is produced.
- R12: `rd_data` shows the register value one cycle after `rd_en`. A read changes no state and does not pulse `lock_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| osc_ready | input | 1 | Oscillator startup complete flag |
| stop_req | input | 1 | Stop mode request |
| osc_pulse | input | 1 | One strobe per oscillator cycle |
| osc_en | output | 1 | Oscillator enable field |
| ref_div_sel | output | 3 | Stored divide code |
| bus_src_osc | output | 1 | Bus clock source field |
| fll_ref_osc | output | 1 | Loop reference source field |
| lowbw_filter | output | 1 | Low-bandwidth filter field |
| ref_tick | output | 1 | Divided reference tick |
| bus_sel_osc | output | 1 | Bus clock mux selects oscillator |
| bus_sel_dco | output | 1 | Bus clock mux selects DCO |
| dco_off | output | 1 | DCO disable |
| lock_clr | output | 1 | Lock-status clear pulse |

## Verification
The hardest state to reach is one where a guarded field sees a conflicting condition at the very edge of a write. Examples are a filter write landing while the oscillator is already enabled, a select set attempted while the startup flag is low, and a stop request arriving while the selects are set. The stimulus builds the register up in steps. It first enables the oscillator with `osc_ready` low, so that the select bits are refused. It then raises the flag and rewrites the register, offering a different filter value that must be refused. After that it pulses stop mode with no write in flight. The divider is timed for every code from the write edge to the first tick and then from tick to tick, with `osc_pulse` held high.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int REG_W    = 8;
  localparam int DSEL_W   = 3;
  localparam logic [DSEL_W-1:0] DSEL_RSVD = 3'b111;

  // bit order matters: it is the software-visible layout
  typedef struct packed {
    logic              osc_en;
    logic [DSEL_W-1:0] div_sel;
    logic              bus_osc;
    logic              ref_osc;
    logic              lowbw;
    logic              unused0;
  } ctl_reg_t;

  // ratio = (base/4 << octave) * (4 + step), octave = code/3, step = code%3
  function automatic int unsigned div_ratio(input logic [DSEL_W-1:0] code,
                                            input int unsigned base);
    int unsigned octave;
    int unsigned step;
    octave = int'(code) / 3;
    step   = int'(code) % 3;
    return ((base / 4) << octave) * (4 + step);
  endfunction

endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             osc_ready,
  input  logic             stop_req,
  output ctl_reg_t         ctl_q,
  output logic [REG_W-1:0] rd_data,
  output logic             lock_clr
);

  ctl_reg_t wd;
  ctl_reg_t nxt;

  assign wd = ctl_reg_t'(wr_data);

  always_comb begin
    nxt = ctl_q;
    if (wr_en) begin
      nxt.osc_en = wd.osc_en;
      if (wd.div_sel != DSEL_RSVD) nxt.div_sel = wd.div_sel;
      if (!wd.bus_osc)    nxt.bus_osc = 1'b0;
      else if (osc_ready) nxt.bus_osc = 1'b1;
      if (!wd.ref_osc)    nxt.ref_osc = 1'b0;
      else if (osc_ready) nxt.ref_osc = 1'b1;
      if (!ctl_q.osc_en)  nxt.lowbw = wd.lowbw;
    end
    if (!nxt.osc_en || stop_req) begin
      nxt.bus_osc = 1'b0;
      nxt.ref_osc = 1'b0;
    end
    nxt.unused0 = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      rd_data  <= '0;
      lock_clr <= 1'b0;
    end else begin
      ctl_q    <= nxt;
      lock_clr <= wr_en;
      if (rd_en) rd_data <= ctl_q;
    end
  end

  p_bus_guard_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q.bus_osc) |-> $past(osc_ready) && $past(wr_en));

  p_ref_guard_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q.ref_osc) |-> $past(osc_ready) && $past(wr_en));

  p_stop_clears_r6: assert property (@(posedge clk) disable iff (rst)
    stop_req |=> !ctl_q.bus_osc && !ctl_q.ref_osc);

  p_filter_lock_r7: assert property (@(posedge clk) disable iff (rst)
    ctl_q.osc_en |=> $stable(ctl_q.lowbw));

  p_lock_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> lock_clr);

  p_rsvd_kept_r10: assert property (@(posedge clk) disable iff (rst)
    ctl_q.div_sel != DSEL_RSVD);

  p_read_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !stop_req) |=> $stable(ctl_q));

endmodule

// File: rtl/clkctl_refdiv.sv
module clkctl_refdiv
  import clkctl_pkg::*;
#(
  parameter int unsigned BASE_RATIO = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DSEL_W-1:0] div_sel,
  input  logic              osc_pulse,
  output logic              ref_tick
);

  localparam int unsigned MAX_RATIO = BASE_RATIO * 4;
  localparam int          CNT_W     = $clog2(MAX_RATIO);

  logic [CNT_W-1:0]  cnt_q;
  logic [DSEL_W-1:0] sel_q;
  logic [CNT_W-1:0]  last_cnt;
  logic              restart;

  always_comb begin
    last_cnt = CNT_W'(div_ratio(div_sel, BASE_RATIO) - 1);
  end

  assign restart = !enable || (div_sel != sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      sel_q    <= '0;
      ref_tick <= 1'b0;
    end else begin
      sel_q    <= div_sel;
      ref_tick <= 1'b0;
      if (restart) begin
        cnt_q <= '0;
      end else if (osc_pulse) begin
        if (cnt_q == last_cnt) begin
          cnt_q    <= '0;
          ref_tick <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
    ref_tick |=> !ref_tick);

  p_no_tick_off_r11: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !ref_tick);

endmodule

// File: rtl/clkctl_clksel.sv
module clkctl_clksel (
  input  logic clk,
  input  logic rst,
  input  logic bus_osc,
  output logic bus_sel_osc,
  output logic bus_sel_dco,
  output logic dco_off
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_sel_osc <= 1'b0;
      bus_sel_dco <= 1'b1;
      dco_off     <= 1'b0;
    end else begin
      bus_sel_osc <= bus_osc;
      bus_sel_dco <= !bus_osc;
      dco_off     <= bus_osc;
    end
  end

  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({bus_sel_osc, bus_sel_dco}) == 1);

  p_sel_follow_r9: assert property (@(posedge clk) disable iff (rst)
    bus_osc |=> bus_sel_osc && dco_off);

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
  import clkctl_pkg::*;
#(
  parameter int unsigned BASE_RATIO = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rd_data,
  input  logic              osc_ready,
  input  logic              stop_req,
  input  logic              osc_pulse,
  output logic              osc_en,
  output logic [DSEL_W-1:0] ref_div_sel,
  output logic              bus_src_osc,
  output logic              fll_ref_osc,
  output logic              lowbw_filter,
  output logic              ref_tick,
  output logic              bus_sel_osc,
  output logic              bus_sel_dco,
  output logic              dco_off,
  output logic              lock_clr
);

  ctl_reg_t ctl;

  clkctl_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .osc_ready (osc_ready),
    .stop_req  (stop_req),
    .ctl_q     (ctl),
    .rd_data   (rd_data),
    .lock_clr  (lock_clr)
  );

  clkctl_refdiv #(.BASE_RATIO(BASE_RATIO)) u_div (
    .clk       (clk),
    .rst       (rst),
    .enable    (ctl.osc_en),
    .div_sel   (ctl.div_sel),
    .osc_pulse (osc_pulse),
    .ref_tick  (ref_tick)
  );

  clkctl_clksel u_sel (
    .clk         (clk),
    .rst         (rst),
    .bus_osc     (ctl.bus_osc),
    .bus_sel_osc (bus_sel_osc),
    .bus_sel_dco (bus_sel_dco),
    .dco_off     (dco_off)
  );

  assign osc_en       = ctl.osc_en;
  assign ref_div_sel  = ctl.div_sel;
  assign bus_src_osc  = ctl.bus_osc;
  assign fll_ref_osc  = ctl.ref_osc;
  assign lowbw_filter = ctl.lowbw;

endmodule

// File: tb/sim_clkctl_top.sv
`timescale 1ns/1ps
module sim_clkctl_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       osc_ready = 1'b0;
  logic       stop_req = 1'b0;
  logic       osc_pulse = 1'b0;
  logic       osc_en, bus_src_osc, fll_ref_osc, lowbw_filter;
  logic [2:0] ref_div_sel;
  logic       ref_tick, bus_sel_osc, bus_sel_dco, dco_off, lock_clr;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  logic rd_pend = 1'b0;

  always #4 clk = ~clk;

  clkctl_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .osc_ready(osc_ready), .stop_req(stop_req),
    .osc_pulse(osc_pulse), .osc_en(osc_en), .ref_div_sel(ref_div_sel),
    .bus_src_osc(bus_src_osc), .fll_ref_osc(fll_ref_osc),
    .lowbw_filter(lowbw_filter), .ref_tick(ref_tick),
    .bus_sel_osc(bus_sel_osc), .bus_sel_dco(bus_sel_dco), .dco_off(dco_off),
    .lock_clr(lock_clr)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int ratio_ref(input int code);
    case (code)
      0: return 128; 1: return 160; 2: return 192; 3: return 256;
      4: return 320; 5: return 384; default: return 512;
    endcase
  endfunction

  // monitor: compares read data against the scoreboard queue
  always @(posedge clk) rd_pend <= rd_en;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 unexpected read actual=%0d expected=none", rd_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, rd_data, e.val);
      end
    end
  end

  task automatic do_write(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] expv, input string tag);
    exp_t e;
    e.val = expv; e.tag = tag;
    exp_q.push_back(e);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic time_code(input int code);
    int n;
    int p;
    int nn;
    nn = ratio_ref(code);
    wr_data = {1'b1, 3'(code), 4'b1100}; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    n = 1;
    while (!ref_tick && n < 2000) begin @(negedge clk); n++; end
    chk($sformatf("R11 first tick delay code %0d", code), n, nn + 2);
    p = 0;
    do begin @(negedge clk); p++; end while (!ref_tick && p < 2000);
    chk($sformatf("R3 tick period code %0d", code), p, nn);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int tk;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 reset lock_clr", lock_clr, 0);
    chk("R2 reset tick", ref_tick, 0);
    chk("R2 reset dco select", bus_sel_dco, 1);
    do_read(8'h00, "R2 reset value");

    // oscillator on, selects refused (not ready), filter accepted
    do_write(8'hBE);
    chk("R8 lock_clr after write", lock_clr, 1);
    @(negedge clk);
    chk("R8 lock_clr one cycle", lock_clr, 0);
    do_read(8'hB2, "R4 R5 selects refused when not ready");

    // ready: selects set, filter change refused
    osc_ready = 1'b1;
    do_write(8'hBC);
    @(negedge clk);
    chk("R9 bus_sel_osc", bus_sel_osc, 1);
    chk("R9 dco_off", dco_off, 1);
    chk("R9 bus_sel_dco", bus_sel_dco, 0);
    do_read(8'hBE, "R4 R5 R7 selects set, filter kept");

    // reserved code and bit 0
    do_write(8'hFF);
    do_read(8'hBE, "R10 R1 reserved code and bit0 ignored");

    // read has no side effect
    rd_en = 1'b1; exp_q.push_back('{8'hBE, "R12 read A"});
    @(negedge clk);
    exp_q.push_back('{8'hBE, "R12 read B"});
    @(negedge clk);
    rd_en = 1'b0;
    chk("R12 no lock_clr on read", lock_clr, 0);
    @(negedge clk);

    // stop mode clears selects
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk("R6 bus cleared on stop", bus_src_osc, 0);
    chk("R6 ref cleared on stop", fll_ref_osc, 0);
    do_read(8'hB2, "R6 register after stop");

    // divider timing for every code
    osc_pulse = 1'b1;
    for (int c = 0; c < 7; c++) time_code(c);

    // oscillator off: selects clear, filter held, ticks stop
    do_write(8'h0C);
    chk("R6 bus cleared on osc off", bus_src_osc, 0);
    do_read(8'h02, "R7 filter held while osc was on");
    tk = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (ref_tick) tk++;
    end
    chk("R11 no ticks while disabled", tk, 0);
    do_write(8'h00);
    do_read(8'h00, "R7 filter writable while osc off");

    repeat (3) @(negedge clk);
    chk("R12 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule